// File: doc/BRIEF.md
# Host Interrupt Status and Enable Unit

This unit keeps the interrupt status and interrupt enable registers of a USB host controller and drives its single interrupt request. Single-cycle event pulses from the transfer engine, the frame timer and the root ports set sticky status bits. Software reads both registers and clears status bits by writing ones. Port activity sets a shared port-change bit. When per-port reporting is switched on, it also sets a status bit of its own for each port, so that software can tell which port raised the event without scanning every port.

Sources fall into two classes. Host system error, frame-list rollover and all port-change bits raise the request as soon as their status and enable bits are both set. Transfer complete, transfer error and async-advance are held back. Their request waits until the microframe pacer reaches the next threshold boundary. The pacer counts microframe ticks against a programmable threshold. Register access is a plain select/write strobe with combinational read data and no handshake.

Top module: `hc_irq_status`

## Requirements
- R1: After reset both registers read 0 and `irq` is low.
- R2: `reg_sel`=0 addresses status and `reg_sel`=1 addresses enable. Both use the same layout: bit 0 transfer complete, bit 1 transfer error, bit 2 shared port change, bit 3 frame-list rollover, bit 4 host system error, bit 5 async advance, and bit 16+p for port p (p from 0 to NUM_PORTS-1). All other bits read 0 and ignore writes.
- R3: A source pulse sets its status bit on the next clock edge whatever the enable bit holds.
- R4: A status write clears the bits written as 1 and leaves the bits written as 0. If a clear and a hardware set reach the same bit in the same cycle, the bit stays set.
- R5: A port raises an event only while its `port_owner` bit is 0, and only on a 0-to-1 edge of its `port_chg` or `port_resume` level.
- R6: Every port event sets bit 2, whatever `perport_en` holds. Clearing bit 2 leaves the per-port bits unchanged.
- R7: A per-port status bit sets on its port's event only while `perport_en` is 1.
- R8: Bits 2, 3, 4 and 16+ drive `irq` high in the same cycle in which their status and enable bits are both 1.
- R9: Bits 0, 1 and 5 drive `irq` only after a threshold boundary has passed since they were set. A boundary is the `uframe_tick` that brings the count of ticks since the last boundary up to `thresh`. The request then holds until the status bit is cleared.
- R10: `irq` is low whenever no status bit is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 = status, 1 = enable |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| ev_xfer_done | input | 1 | Transfer complete pulse |
| ev_xfer_err | input | 1 | Transfer error pulse |
| ev_async_adv | input | 1 | Async advance pulse |
| ev_sys_err | input | 1 | Host system error pulse |
| ev_rollover | input | 1 | Frame-list rollover pulse |
| port_chg | input | NUM_PORTS | Per-port change-bit levels |
| port_resume | input | NUM_PORTS | Per-port resume-detect levels |
| port_owner | input | NUM_PORTS | 1 = port handed to a companion controller |
| perport_en | input | 1 | Enables per-port status bits |
| uframe_tick | input | 1 | One pulse per microframe |
| thresh | input | 8 | Threshold in microframes |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with NUM_PORTS=4. With that value a write of all ones to the enable register shows exactly where the valid port field ends, and ports can be mixed freely: an owned port, a resume edge and per-port bits next to the shared bit. The threshold is held at 2 microframes. A deferred request then has to stay quiet through one tick and rise on the second, and the bench can keep track of the pacer count by issuing ticks in pairs.

// File: rtl/hcis_pkg.sv
package hcis_pkg;
  localparam int REG_W     = 32;
  localparam int B_XFER    = 0;
  localparam int B_ERR     = 1;
  localparam int B_PORT    = 2;
  localparam int B_ROLL    = 3;
  localparam int B_SYSERR  = 4;
  localparam int B_ASYNC   = 5;
  localparam int B_PP_BASE = 16;
  localparam int N_DEFER   = 3;
  localparam logic [REG_W-1:0] CORE_MASK  = 32'h0000_003F;
  localparam logic [REG_W-1:0] DEFER_MASK = 32'h0000_0023;
endpackage

// File: rtl/hcis_port_detect.sv
module hcis_port_detect #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] chg_lvl,
  input  logic [NUM_PORTS-1:0] rsm_lvl,
  input  logic [NUM_PORTS-1:0] owner,
  output logic [NUM_PORTS-1:0] evt
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic chg_d, rsm_d;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chg_d <= 1'b0;
        rsm_d <= 1'b0;
      end else begin
        chg_d <= chg_lvl[p];
        rsm_d <= rsm_lvl[p];
      end
    end
    // only host-owned ports report; a rise of either level counts
    assign evt[p] = !owner[p] && ((chg_lvl[p] && !chg_d) || (rsm_lvl[p] && !rsm_d));
  end
endmodule

// File: rtl/hcis_uframe_pacer.sv
module hcis_uframe_pacer #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] thresh,
  output logic       boundary
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign boundary = tick && ({{(8 - CNT_W - 1){1'b0}}, cnt_inc} >= thresh);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (boundary) cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_inc[CNT_W-1:0];
  end
endmodule

// File: rtl/hcis_defer_gate.sv
module hcis_defer_gate #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         boundary,
  input  logic [N-1:0] sts_cur,
  input  logic [N-1:0] sts_nxt,
  output logic [N-1:0] released
);
  always_ff @(posedge clk) begin
    if (!rst_n) released <= '0;
    else        released <= (released | ({N{boundary}} & sts_cur)) & sts_nxt;
  end
endmodule

// File: rtl/hc_irq_status.sv
module hc_irq_status
  import hcis_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_sel,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 ev_xfer_done,
  input  logic                 ev_xfer_err,
  input  logic                 ev_async_adv,
  input  logic                 ev_sys_err,
  input  logic                 ev_rollover,
  input  logic [NUM_PORTS-1:0] port_chg,
  input  logic [NUM_PORTS-1:0] port_resume,
  input  logic [NUM_PORTS-1:0] port_owner,
  input  logic                 perport_en,
  input  logic                 uframe_tick,
  input  logic [7:0]           thresh,
  output logic                 irq
);
  localparam logic [REG_W-1:0] PORT_MASK  = ((REG_W'(1) << NUM_PORTS) - 1) << B_PP_BASE;
  localparam logic [REG_W-1:0] VALID_MASK = PORT_MASK | CORE_MASK;

  logic [REG_W-1:0]     sts_q, sts_nxt, en_q, set_vec, clr_vec, live, rel_vec;
  logic [NUM_PORTS-1:0] port_evt;
  logic                 boundary;
  logic [N_DEFER-1:0]   def_cur, def_nxt, def_rel;

  hcis_port_detect #(.NUM_PORTS(NUM_PORTS)) u_ports (
    .clk(clk), .rst_n(rst_n), .chg_lvl(port_chg), .rsm_lvl(port_resume),
    .owner(port_owner), .evt(port_evt)
  );

  hcis_uframe_pacer #(.CNT_W(7)) u_pacer (
    .clk(clk), .rst_n(rst_n), .tick(uframe_tick), .thresh(thresh), .boundary(boundary)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[B_XFER]    = ev_xfer_done;
    set_vec[B_ERR]     = ev_xfer_err;
    set_vec[B_PORT]    = |port_evt;
    set_vec[B_ROLL]    = ev_rollover;
    set_vec[B_SYSERR]  = ev_sys_err;
    set_vec[B_ASYNC]   = ev_async_adv;
    set_vec[B_PP_BASE +: NUM_PORTS] = perport_en ? port_evt : '0;
    clr_vec = (reg_wr && !reg_sel) ? (reg_wdata & VALID_MASK) : '0;
    // a hardware set overrides a same-cycle software clear
    sts_nxt = (sts_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_nxt;
      if (reg_wr && reg_sel) en_q <= reg_wdata & VALID_MASK;
    end
  end

  assign def_cur = {sts_q[B_ASYNC], sts_q[B_ERR], sts_q[B_XFER]};
  assign def_nxt = {sts_nxt[B_ASYNC], sts_nxt[B_ERR], sts_nxt[B_XFER]};

  hcis_defer_gate #(.N(N_DEFER)) u_defer (
    .clk(clk), .rst_n(rst_n), .boundary(boundary),
    .sts_cur(def_cur), .sts_nxt(def_nxt), .released(def_rel)
  );

  always_comb begin
    rel_vec          = ~DEFER_MASK;
    rel_vec[B_XFER]  = def_rel[0];
    rel_vec[B_ERR]   = def_rel[1];
    rel_vec[B_ASYNC] = def_rel[2];
    live             = sts_q & en_q & rel_vec;
  end

  assign irq       = |live;
  assign reg_rdata = reg_sel ? en_q : sts_q;
endmodule

// File: rtl/hc_irq_status_chk.sv
module hc_irq_status_chk #(
  parameter int NUM_PORTS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_sel,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic        ev_sys_err,
  input logic        perport_en,
  input logic [31:0] sts_q,
  input logic [31:0] en_q,
  input logic        irq
);
  // R3
  sys_err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sys_err |=> sts_q[4]);
  // R4
  sticky_until_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[4] && !(reg_wr && !reg_sel && reg_wdata[4])) |=> sts_q[4]);
  // R7
  perport_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !perport_en |=> ((sts_q[31:16] & ~$past(sts_q[31:16])) == 16'h0));
  // R8
  immediate_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[4] && en_q[4]) |-> irq);
  // R10
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & en_q) == 32'h0) |-> !irq);
endmodule

bind hc_irq_status hc_irq_status_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .ev_sys_err(ev_sys_err), .perport_en(perport_en), .sts_q(sts_q), .en_q(en_q), .irq(irq)
);

// File: tb/hc_irq_status_bench.sv
module hc_irq_status_bench;
  localparam int NP = 4;
  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_wr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ev_xfer_done = 0, ev_xfer_err = 0, ev_async_adv = 0, ev_sys_err = 0, ev_rollover = 0;
  logic [NP-1:0] port_chg = 0, port_resume = 0, port_owner = 0;
  logic perport_en = 0, uframe_tick = 0, irq;
  logic [7:0] thresh = 8'h02;
  int checks = 0, errors = 0;

  typedef struct { logic sel; logic [31:0] data; logic irq; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  hc_irq_status #(.NUM_PORTS(NP)) u_hc_irq_status (.*);

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks += 2;
      if (reg_rdata !== e.data) begin
        errors++;
        $display("FAIL %s sel=%0d data got %h exp %h", e.tag, e.sel, reg_rdata, e.data);
      end
      if (irq !== e.irq) begin
        errors++;
        $display("FAIL %s irq got %b exp %b", e.tag, irq, e.irq);
      end
    end
  end

  task automatic look(input logic s, input logic [31:0] d, input logic i, input string tag);
    exp_t e;
    reg_sel = s;
    e.sel = s; e.data = d; e.irq = i; e.tag = tag;
    q.push_back(e);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic s, input logic [31:0] d);
    reg_sel = s; reg_wr = 1; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick();
    uframe_tick = 1; step(); uframe_tick = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    look(0, 32'h0, 0, "R1 status");
    look(1, 32'h0, 0, "R1 enable");

    wr(1, 32'hFFFF_FFFF);
    look(1, 32'h000F_003F, 0, "R2 valid bits");
    wr(1, 32'h0);

    ev_sys_err = 1; step(); ev_sys_err = 0;
    look(0, 32'h10, 0, "R3 sets with enable off");
    wr(1, 32'h10);
    look(0, 32'h10, 1, "R8 sys err immediate");
    wr(0, 32'h10);
    look(0, 32'h0, 0, "R10 cleared");
    wr(1, 32'h0);

    ev_rollover = 1; step(); ev_rollover = 0;
    reg_sel = 0; reg_wr = 1; reg_wdata = 32'h8; ev_rollover = 1;
    step(); reg_wr = 0; ev_rollover = 0;
    look(0, 32'h8, 0, "R4 set beats clear");
    wr(0, 32'h0);
    look(0, 32'h8, 0, "R4 zero write keeps");
    wr(0, 32'h8);
    look(0, 32'h0, 0, "R4 w1c");

    port_chg[1] = 1; step();
    look(0, 32'h4, 0, "R6 shared bit without per-port");
    perport_en = 1;
    wr(0, 32'h4);
    look(0, 32'h0, 0, "R5 held level no new event");
    port_chg[1] = 0; step(); port_chg[1] = 1; step();
    look(0, 32'h0002_0004, 0, "R7 per-port bit 17");
    port_owner[3] = 1; port_chg[3] = 1; step();
    look(0, 32'h0002_0004, 0, "R5 owned port ignored");
    port_resume[0] = 1; step();
    look(0, 32'h0003_0004, 0, "R5 resume edge");
    wr(1, 32'h0002_0000);
    look(0, 32'h0003_0004, 1, "R8 per-port immediate");
    wr(0, 32'h4);
    look(0, 32'h0003_0000, 1, "R6 shared clear independent");
    wr(0, 32'h0003_0000);
    look(0, 32'h0, 0, "R10 all cleared");

    wr(1, 32'h23);
    ev_xfer_done = 1; step(); ev_xfer_done = 0;
    look(0, 32'h1, 0, "R9 deferred held");
    tick();
    look(0, 32'h1, 0, "R9 before boundary");
    tick();
    look(0, 32'h1, 1, "R9 at boundary");
    wr(0, 32'h1);
    look(0, 32'h0, 0, "R10 deferred cleared");
    tick(); tick();
    ev_xfer_err = 1; step(); ev_xfer_err = 0;
    look(0, 32'h2, 0, "R9 error deferred");
    tick(); tick();
    look(0, 32'h2, 1, "R9 error released");
    wr(0, 32'h2);
    wr(1, 32'h8);
    ev_rollover = 1; step(); ev_rollover = 0;
    look(0, 32'h8, 1, "R8 rollover immediate");

    wait (q.size() == 0);
    @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule